// File: doc/BRIEF.md
# MPEG Transport Frame Synchronizer

This block sits behind a QAM symbol-to-byte mapper and finds the MPEG transport packet framing in the recovered byte stream. A packet on the line is 204 bytes long (188 payload bytes plus 16 parity bytes). The first byte of each packet is a sync marker. The block accepts both the normal marker (0x47) and its bitwise inverse (0xB8).

While it has no alignment, the block hunts byte by byte for a marker. The first marker it finds becomes a candidate alignment. After that it looks only at the byte positions one packet length apart. Once the run of aligned markers is longer than a programmable acquisition threshold, the block declares lock. While locked, it keeps the packet period running through missing markers. It gives up and returns to hunting only when the run of consecutive missing markers is longer than a programmable miss threshold.

The byte stream is passed through with one cycle of delay. A lock flag and a one-byte frame-start pulse travel beside the bytes and give the frame alignment to the error-correction stage downstream.

Top module: `mpeg_frame_sync`

## Requirements
- R1: While reset is asserted, and after it, until the first byte is accepted, `locked`, `frame_start` and `out_valid` are 0. Asserting `rst_n` low clears `locked` without waiting for a clock.
- R2: A byte counts as a sync marker when it equals 0x47 or 0xB8. Any other value is not a marker.
- R3: In the hunt state, every valid byte is tested and the first marker becomes the candidate. From then on, only the bytes exactly 204 valid bytes apart from the candidate are tested. A marker value at any other position (for example, payload byte 100) has no effect.
- R4: The count of aligned markers includes the candidate. Lock is declared on the aligned marker that makes this count greater than `acq_thresh`.
- R5: If a candidate is being verified and the byte at its expected aligned position is not a marker, the block returns to hunting without locking. Hunting resumes at the next byte.
- R6: While locked, `frame_start` is 1 for exactly one output byte: the first byte of each frame. This includes frames whose marker is missing but whose miss count does not drop lock.
- R7: While locked, each missing marker at an aligned position adds one to a consecutive-miss count, and a correct marker clears it. Lock drops on the aligned byte where the count becomes greater than `miss_thresh`.
- R8: `frame_start` is never 1 while `locked` is 0. It is also 0 on the byte where lock drops.
- R9: `out_byte` and `out_valid` repeat `in_byte` and `in_valid` one clock later. `locked` and `frame_start` refer to the byte currently on `out_byte`.
- R10: Cycles with `in_valid` = 0 do not advance the packet position and are never taken as markers, whatever `in_byte` holds.
- R11: A new value of `acq_thresh` takes effect at the next aligned comparison while a candidate is being verified.
- R12: With `acq_thresh` = 0, the first marker found by hunting declares lock on that same byte and raises `frame_start` with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_byte | input | 8 | Byte from the symbol-to-byte mapper |
| in_valid | input | 1 | `in_byte` carries a new byte this cycle |
| acq_thresh | input | 4 | Lock is declared when the aligned marker count exceeds this value |
| miss_thresh | input | 4 | Lock is dropped when the consecutive miss count exceeds this value |
| out_byte | output | 8 | Byte delayed by one cycle |
| out_valid | output | 1 | `out_byte` is a new byte |
| frame_start | output | 1 | `out_byte` is the first byte of a frame (locked only) |
| locked | output | 1 | Frame alignment is established |

## Verification
Every result for an accepted byte is due in the single clock after that byte's edge. The byte, the valid flag, the lock flag and the frame-start pulse all leave the same output register. After `rst_n` rises, the internal reset release takes two more clock edges before any byte is taken.

The bench drives inputs on the falling edge and samples the outputs 1 ns after the rising edge that captured the byte. Each sample is therefore paired with exactly one input byte. Checks on lock and frame-start are made on the output cycle of each frame's first byte. The number of valid bytes between two such cycles is computed from the 204-byte period and from any prefix bytes or invalid gap cycles the bench inserts.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCK   = 2'd2
  } sync_state_e;

endpackage

// File: rtl/mfs_sync_detect.sv
module mfs_sync_detect #(
  parameter logic [7:0] SYNC_BYTE       = 8'h47,
  parameter bit         ACCEPT_INVERTED = 1'b1
) (
  input  logic [7:0] byte_i,
  output logic       is_sync_o
);

  localparam logic [7:0] SYNC_INV = ~SYNC_BYTE;

  // R2: normal marker, plus its bitwise inverse when enabled
  generate
    if (ACCEPT_INVERTED) begin : g_both
      assign is_sync_o = (byte_i == SYNC_BYTE) || (byte_i == SYNC_INV);
    end else begin : g_plain
      assign is_sync_o = (byte_i == SYNC_BYTE);
    end
  endgenerate

endmodule

// File: rtl/mfs_frame_pos.sv
module mfs_frame_pos #(
  parameter int FRAME_LEN = 204,
  parameter int POS_W     = $clog2(FRAME_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,      // a valid byte is consumed
  input  logic restart_i,  // current byte is a new candidate (position 0)
  output logic bound_o     // current byte sits on a frame boundary
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] ONE_POS  = POS_W'(1);

  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (adv_i) begin
      if (restart_i)             pos_d = ONE_POS;
      else if (pos_q == LAST_POS) pos_d = '0;
      else                        pos_d = pos_q + ONE_POS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else if (adv_i) pos_q <= pos_d;
  end

  assign bound_o = (pos_q == '0);

  // R10: an idle cycle leaves the packet position untouched
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(pos_q));

  // R3: a new candidate anchors the count so the next byte is position 1
  p_restart_anchor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && restart_i |=> pos_q == ONE_POS);

endmodule

// File: rtl/mfs_lock_fsm.sv
module mfs_lock_fsm
  import mfs_pkg::*;
#(
  parameter int THR_W = 4,
  parameter int CNT_W = THR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en_i,
  input  logic             is_sync_i,
  input  logic             bound_i,
  input  logic [THR_W-1:0] acq_thresh_i,
  input  logic [THR_W-1:0] miss_thresh_i,
  output logic             restart_o,
  output logic             start_next_o,
  output sync_state_e      state_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  sync_state_e      state_q, state_d;
  logic [CNT_W-1:0] hit_q, hit_d, miss_q, miss_d;
  logic [CNT_W-1:0] hit_inc, miss_inc, acq_ext, miss_ext;
  logic             slot;

  assign hit_inc  = hit_q + CNT_ONE;
  assign miss_inc = miss_q + CNT_ONE;
  assign acq_ext  = {1'b0, acq_thresh_i};
  assign miss_ext = {1'b0, miss_thresh_i};

  always_comb begin
    state_d   = state_q;
    hit_d     = hit_q;
    miss_d    = miss_q;
    restart_o = 1'b0;
    slot      = 1'b0;
    if (byte_en_i) begin
      unique case (state_q)
        ST_HUNT: begin
          if (is_sync_i) begin
            restart_o = 1'b1;
            slot      = 1'b1;
            hit_d     = CNT_ONE;
            miss_d    = '0;
            state_d   = (CNT_ONE > acq_ext) ? ST_LOCK : ST_VERIFY;
          end
        end
        ST_VERIFY: begin
          if (bound_i) begin
            if (is_sync_i) begin
              slot  = 1'b1;
              hit_d = hit_inc;
              if (hit_inc > acq_ext) begin
                state_d = ST_LOCK;
                miss_d  = '0;
              end
            end else begin
              state_d = ST_HUNT;
            end
          end
        end
        ST_LOCK: begin
          if (bound_i) begin
            slot   = 1'b1;
            miss_d = is_sync_i ? '0 : miss_inc;
            if (!is_sync_i && (miss_inc > miss_ext)) state_d = ST_HUNT;
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  // R6/R8: a frame start only where the byte leaves the block in lock
  assign start_next_o = slot && (state_d == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      hit_q   <= '0;
      miss_q  <= '0;
    end else if (byte_en_i) begin
      state_q <= state_d;
      hit_q   <= hit_d;
      miss_q  <= miss_d;
    end
  end

  assign state_o = state_q;

  // R3: hunting continues over any byte that is not a marker
  p_hunt_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_HUNT && byte_en_i && !is_sync_i |=> state_q == ST_HUNT);

  // R3: bytes off the frame boundary never move an aligned state
  p_mid_frame_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != ST_HUNT && byte_en_i && !bound_i |=> $stable(state_q) && $stable(hit_q) && $stable(miss_q));

  // R5: a failed verification returns to hunting
  p_verify_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_VERIFY && byte_en_i && bound_i && !is_sync_i |=> state_q == ST_HUNT);

  // R7: a good aligned marker keeps lock and clears the miss run
  p_good_sync_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_LOCK && byte_en_i && bound_i && is_sync_i |=> state_q == ST_LOCK && miss_q == '0);

  // R7: the miss run never goes beyond the programmed limit while locked
  p_miss_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_LOCK && $stable(miss_thresh_i) |-> miss_q <= miss_ext);

endmodule

// File: rtl/mpeg_frame_sync.sv
module mpeg_frame_sync
  import mfs_pkg::*;
#(
  parameter int         FRAME_LEN       = 204,
  parameter logic [7:0] SYNC_BYTE       = 8'h47,
  parameter bit         ACCEPT_INVERTED = 1'b1,
  parameter int         THR_W           = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_byte,
  input  logic             in_valid,
  input  logic [THR_W-1:0] acq_thresh,
  input  logic [THR_W-1:0] miss_thresh,
  output logic [7:0]       out_byte,
  output logic             out_valid,
  output logic             frame_start,
  output logic             locked
);

  localparam int POS_W = $clog2(FRAME_LEN);
  localparam int CNT_W = THR_W + 1;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic        is_sync, bound, restart, start_next;
  sync_state_e state;

  mfs_sync_detect #(
    .SYNC_BYTE       (SYNC_BYTE),
    .ACCEPT_INVERTED (ACCEPT_INVERTED)
  ) u_detect (
    .byte_i    (in_byte),
    .is_sync_o (is_sync)
  );

  mfs_frame_pos #(
    .FRAME_LEN (FRAME_LEN),
    .POS_W     (POS_W)
  ) u_pos (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .adv_i     (in_valid),
    .restart_i (restart),
    .bound_o   (bound)
  );

  mfs_lock_fsm #(
    .THR_W (THR_W),
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .byte_en_i     (in_valid),
    .is_sync_i     (is_sync),
    .bound_i       (bound),
    .acq_thresh_i  (acq_thresh),
    .miss_thresh_i (miss_thresh),
    .restart_o     (restart),
    .start_next_o  (start_next),
    .state_o       (state)
  );

  // output stage: byte, valid and frame marker leave together
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_byte    <= '0;
      out_valid   <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      frame_start <= start_next;
      if (in_valid) out_byte <= in_byte;
    end
  end

  assign locked = (state == ST_LOCK);

  // R8: frame start only while locked
  p_start_needs_lock_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_start |-> locked && out_valid);

  // R6: frame start lasts a single byte
  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_start |=> !frame_start);

  // R4: lock is always gained on a frame's first byte
  p_lock_on_frame_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(locked) |-> frame_start);

  // R9: one-cycle pass-through of the byte stream
  p_passthru_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid && out_byte == $past(in_byte));

  // R10: an idle input cycle produces no output byte
  p_idle_out_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid && !frame_start);

endmodule

// File: tb/mpeg_frame_sync_bench.sv
module mpeg_frame_sync_bench;

  localparam int FLEN = 204;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] in_byte;
  logic       in_valid;
  logic [3:0] acq_thresh, miss_thresh;
  logic [7:0] out_byte;
  logic       out_valid, frame_start, locked;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  mpeg_frame_sync u_mpeg_frame_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_byte     (in_byte),
    .in_valid    (in_valid),
    .acq_thresh  (acq_thresh),
    .miss_thresh (miss_thresh),
    .out_byte    (out_byte),
    .out_valid   (out_valid),
    .frame_start (frame_start),
    .locked      (locked)
  );

  // scenario vector: thresholds, frame count, per-frame marker present,
  // inverted marker, payload marker at byte 100, expected lock at frame start
  typedef struct packed {
    logic [3:0] acq;
    logic [3:0] miss;
    logic [3:0] nfr;
    logic [7:0] mask;
    logic [7:0] inv;
    logic [7:0] poison;
    logic [7:0] exp_lock;
    logic       gap;
    logic       stray;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    // R2 R4 R10: both markers, gaps of idle cycles holding 0x47
    '{4'd2, 4'd1, 4'd6, 8'b00111111, 8'b00101010, 8'h00,       8'b00111100, 1'b1, 1'b0},
    // R6 R7: flywheel over one miss, drop at the second
    '{4'd1, 4'd1, 4'd6, 8'b00100111, 8'b00000101, 8'h00,       8'b00001110, 1'b0, 1'b0},
    // R3 R5: failed verification, then payload marker ignored
    '{4'd3, 4'd0, 4'd7, 8'b01111101, 8'b00000000, 8'b00000100, 8'b01100000, 1'b0, 1'b0},
    // R12 R7: zero acquisition threshold, drop and relock
    '{4'd0, 4'd0, 4'd4, 8'b00001101, 8'b00000100, 8'h00,       8'b00001101, 1'b0, 1'b0},
    // R7: alternate misses never accumulate
    '{4'd0, 4'd1, 4'd5, 8'b00010101, 8'b00010100, 8'h00,       8'b00011111, 1'b0, 1'b0},
    // R3: stray marker ahead of the stream delays the candidate
    '{4'd1, 4'd0, 4'd4, 8'b00001111, 8'b00000000, 8'h00,       8'b00001100, 1'b0, 1'b1}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R2 R4 R10";
      1: return "R6 R7";
      2: return "R3 R5";
      3: return "R12 R7";
      4: return "R7";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [7:0] filler(input int k);
    return 8'((k * 5) & 63);  // never 0x47 or 0xB8
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // drive on the falling edge, sample 1 ns after the capturing rising edge
  task automatic send(input logic [7:0] b, input logic v);
    @(negedge clk);
    in_byte  = b;
    in_valid = v;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_byte  = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one 204-byte frame; checks the first-byte output and the rest in bulk
  task automatic run_frame(input bit present, input bit inv, input bit poison, input bit gap,
                           input bit exp_lock, input string tag);
    bit bad = 1'b0;
    logic [7:0] b;
    for (int k = 0; k < FLEN; k++) begin
      if (k == 0)                b = present ? (inv ? 8'hB8 : 8'h47) : 8'h00;
      else if (poison && k == 100) b = 8'h47;
      else                       b = filler(k);
      send(b, 1'b1);
      if (k == 0) begin
        check(locked == exp_lock, {tag, " locked at frame start"}, locked, exp_lock);
        check(frame_start == exp_lock, {tag, " R8 frame_start at frame start"}, frame_start, exp_lock);
      end else if (frame_start !== 1'b0) begin
        bad = 1'b1;
      end
      if (out_valid !== 1'b1 || out_byte !== b) bad = 1'b1;
      if (gap) begin
        send(8'h47, 1'b0);
        if (out_valid !== 1'b0 || frame_start !== 1'b0) bad = 1'b1;
      end
    end
    check(!bad, {tag, " R6 R9 R10 frame body output"}, int'(bad), 0);
  endtask

  initial begin
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    in_byte     = 8'h00;
    acq_thresh  = 4'd0;
    miss_thresh = 4'd0;

    // R1: outputs quiet during and just after reset
    repeat (2) @(negedge clk);
    check(locked == 1'b0 && frame_start == 1'b0 && out_valid == 1'b0,
          "R1 outputs in reset", {locked, frame_start, out_valid}, 0);
    do_reset();
    check(locked == 1'b0 && frame_start == 1'b0 && out_valid == 1'b0,
          "R1 outputs after reset", {locked, frame_start, out_valid}, 0);

    // table of scenarios
    for (int v = 0; v < NV; v++) begin
      acq_thresh  = VECS[v].acq;
      miss_thresh = VECS[v].miss;
      do_reset();
      if (VECS[v].stray) begin
        send(8'h47, 1'b1);
        for (int k = 1; k < 50; k++) send(filler(k), 1'b1);
      end else begin
        for (int k = 1; k < 6; k++) send(filler(k), 1'b1);
      end
      for (int f = 0; f < int'(VECS[v].nfr); f++)
        run_frame(VECS[v].mask[f], VECS[v].inv[f], VECS[v].poison[f], VECS[v].gap,
                  VECS[v].exp_lock[f], vec_tag(v));
    end

    // R1: asynchronous clear of lock (scenario above ended locked)
    check(locked == 1'b1, "R1 precondition locked", locked, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(locked == 1'b0, "R1 lock cleared by async reset", locked, 0);
    rst_n = 1'b1;

    // R11: lower the acquisition threshold during verification
    acq_thresh  = 4'd5;
    miss_thresh = 4'd0;
    do_reset();
    for (int k = 1; k < 6; k++) send(filler(k), 1'b1);
    run_frame(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
    run_frame(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
    acq_thresh = 4'd1;
    run_frame(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R11");

    // R2: a near-miss value (0x46) is not a marker while hunting
    acq_thresh = 4'd0;
    do_reset();
    send(8'h46, 1'b1);
    check(locked == 1'b0 && frame_start == 1'b0, "R2 value 0x46 rejected", locked, 0);
    send(8'hB8, 1'b1);
    check(locked == 1'b1 && frame_start == 1'b1, "R2 R12 inverted marker locks", locked, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule